// File: doc/BRIEF.md
# Stack Call and Interrupt Sequencer

This block moves the program counter and the status byte between the processor's registers and a byte-wide stack memory. It carries out four operations: entering a subroutine, leaving it, taking an interrupt, and returning from an interrupt. Each operation takes a few clock cycles and makes exactly one stack access per cycle. The stack is a synchronous single-port memory. Read data comes back one cycle after its address.

The stack address joins two parts. The high byte is chosen by a page select input: 00h or 01h. The low byte is the 8-bit stack pointer, which wraps inside its page. On an interrupt the block stacks the return address first and the status byte after it. It then sets the interrupt disable flag (status bit 2) and jumps to the vector given with the request. An interrupt request made while that flag is 1 is refused.

Handshake: a request is taken on a clock edge where `busy` is low. `busy` stays high while stack accesses run. `done` then pulses for one cycle, and in that cycle the final register values are visible.

Top module: `stack_seq`

## Requirements
- R1: After synchronous reset, `pc_o` is 0000h, `sp_o` is FFh, `status_o` is 00h, and `busy` and `done` are both 0.
- R2: Every stack access uses address bits [15:9] = 0, bit 8 = `page_sel`, and bits [7:0] from the pointer. A write goes to the current pointer. A read goes to the pointer plus one.
- R3: A call (`req_op` = 2'b00) writes PC[15:8] at the pointer and PC[7:0] at the pointer minus one. It leaves the pointer lower by 2 and loads `req_addr` into the PC. `busy` is high for 2 cycles.
- R4: A return (`req_op` = 2'b01) reads PC[7:0] from pointer+1 and PC[15:8] from pointer+2. It leaves the pointer higher by 2. `busy` is high for 3 cycles.
- R5: An interrupt entry (`req_op` = 2'b10) writes PC[15:8], then PC[7:0], then the status byte at falling addresses. It lowers the pointer by 3, loads `req_addr` as the vector, and sets status bit 2 while keeping the other status bits. `busy` is high for 3 cycles.
- R6: A return from interrupt (`req_op` = 2'b11) reads the status byte from pointer+1, PC[7:0] from pointer+2 and PC[15:8] from pointer+3. It raises the pointer by 3. `busy` is high for 4 cycles.
- R7: An interrupt entry request made while status bit 2 is 1 is refused. `busy` stays low, nothing is written, and PC, pointer and status keep their values.
- R8: The pointer wraps modulo 256 in both directions, and the address stays within the selected page.
- R9: `done` is high for exactly one cycle: the cycle after `busy` falls. The new PC, pointer and status values are visible in that cycle.
- R10: A request made while `busy` is high is ignored. No stack write happens while `busy` is low.
- R11: The pointer does not change while idle. A call followed by a return, or an interrupt entry followed by a return from interrupt, gives back the pointer value from before the pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 00 call, 01 return, 10 interrupt entry, 11 return from interrupt |
| req_addr | input | 16 | Call target or interrupt vector |
| page_sel | input | 1 | Stack page: 0 selects 00xxh, 1 selects 01xxh |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_we | output | 1 | Stack memory write enable |
| mem_rdata | input | 8 | Stack memory read data, one cycle after address |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status byte, bit 2 is interrupt disable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs nested calls and returns in page 0 to show last-in-first-out byte order. It then runs an interrupt on top of a call in page 1, which shows page routing and where the status byte goes on the stack. A masked interrupt and a return request issued mid-sequence show refusal and the ignoring of requests. Pops and pushes across pointer FFh/00h show the wrap. A return from interrupt from a preloaded status value of C3h shows that the restored flags are stacked again unchanged, and that only bit 2 gets set on the next entry.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_CALL = 2'b00,
        OP_RET  = 2'b01,
        OP_INT  = 2'b10,
        OP_RETI = 2'b11
    } seq_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_PS,
        ST_POP_PS,
        ST_POP_LO,
        ST_POP_HI,
        ST_POP_END
    } seq_state_e;

    typedef enum logic [1:0] {
        WSRC_PCH,
        WSRC_PCL,
        WSRC_PS
    } wsrc_e;

    typedef struct packed {
        logic  accept;
        logic  mem_we;
        wsrc_e wsrc;
        logic  rd_pre_inc;
        logic  sp_dec;
        logic  sp_inc;
        logic  cap_ps;
        logic  cap_pcl;
        logic  cap_pch;
        logic  load_target;
        logic  set_idis;
        logic  finish;
    } seq_ctrl_t;

    function automatic seq_state_e first_state(input seq_op_e op);
        case (op)
            OP_CALL, OP_INT: return ST_PUSH_HI;
            OP_RET:          return ST_POP_LO;
            default:         return ST_POP_PS;
        endcase
    endfunction

endpackage

// File: rtl/stack_seq_agen.sv
module stack_seq_agen #(
    parameter int PAGE_W = 8,
    parameter int SP_W   = 8
) (
    input  logic                   page_sel,
    input  logic [SP_W-1:0]        sp,
    input  logic                   pre_inc,
    output logic [PAGE_W+SP_W-1:0] addr
);
    logic [SP_W-1:0] low_byte;

    always_comb begin
        low_byte = pre_inc ? sp + SP_W'(1) : sp;
        addr     = {{(PAGE_W-1){1'b0}}, page_sel, low_byte};
    end
endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       idis,
    output seq_ctrl_t  ctrl,
    output logic       busy,
    output logic       done
);
    seq_state_e state_q, state_d;
    seq_op_e    op_q;
    seq_op_e    op_in;

    assign op_in = seq_op_e'(req_op);
    assign busy  = (state_q != ST_IDLE);

    always_comb begin
        ctrl    = '0;
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (req_valid && !(op_in == OP_INT && idis)) begin
                    ctrl.accept = 1'b1;
                    state_d     = first_state(op_in);
                end
            end
            ST_PUSH_HI: begin
                ctrl.mem_we = 1'b1;
                ctrl.wsrc   = WSRC_PCH;
                ctrl.sp_dec = 1'b1;
                state_d     = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                ctrl.mem_we = 1'b1;
                ctrl.wsrc   = WSRC_PCL;
                ctrl.sp_dec = 1'b1;
                if (op_q == OP_CALL) begin
                    ctrl.load_target = 1'b1;
                    ctrl.finish      = 1'b1;
                    state_d          = ST_IDLE;
                end else begin
                    state_d = ST_PUSH_PS;
                end
            end
            ST_PUSH_PS: begin
                ctrl.mem_we      = 1'b1;
                ctrl.wsrc        = WSRC_PS;
                ctrl.sp_dec      = 1'b1;
                ctrl.set_idis    = 1'b1;
                ctrl.load_target = 1'b1;
                ctrl.finish      = 1'b1;
                state_d          = ST_IDLE;
            end
            ST_POP_PS: begin
                ctrl.rd_pre_inc = 1'b1;
                ctrl.sp_inc     = 1'b1;
                state_d         = ST_POP_LO;
            end
            ST_POP_LO: begin
                ctrl.cap_ps     = (op_q == OP_RETI);
                ctrl.rd_pre_inc = 1'b1;
                ctrl.sp_inc     = 1'b1;
                state_d         = ST_POP_HI;
            end
            ST_POP_HI: begin
                ctrl.cap_pcl    = 1'b1;
                ctrl.rd_pre_inc = 1'b1;
                ctrl.sp_inc     = 1'b1;
                state_d         = ST_POP_END;
            end
            ST_POP_END: begin
                ctrl.cap_pch = 1'b1;
                ctrl.finish  = 1'b1;
                state_d      = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_CALL;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= ctrl.finish;
            if (ctrl.accept) op_q <= op_in;
        end
    end
endmodule

// File: rtl/stack_seq_regs.sv
module stack_seq_regs
    import stack_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SP_W     = 8,
    parameter int IDIS_BIT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  wsrc_e               wsrc,
    input  logic                sp_dec,
    input  logic                sp_inc,
    input  logic                cap_ps,
    input  logic                cap_pcl,
    input  logic                cap_pch,
    input  logic                load_target,
    input  logic                set_idis,
    input  logic [2*DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   rdata,
    output logic [2*DATA_W-1:0] pc,
    output logic [SP_W-1:0]     sp,
    output logic [DATA_W-1:0]   status,
    output logic [DATA_W-1:0]   wdata
);
    localparam int PC_W = 2 * DATA_W;

    logic [PC_W-1:0] target_q;

    always_comb begin
        case (wsrc)
            WSRC_PCH: wdata = pc[PC_W-1:DATA_W];
            WSRC_PCL: wdata = pc[DATA_W-1:0];
            default:  wdata = status;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc       <= '0;
            sp       <= '1;
            status   <= '0;
            target_q <= '0;
        end else begin
            if (accept) target_q <= req_addr;
            if (sp_dec)
                sp <= sp - SP_W'(1);
            else if (sp_inc)
                sp <= sp + SP_W'(1);
            if (cap_ps)   status <= rdata;
            if (set_idis) status[IDIS_BIT] <= 1'b1;
            if (load_target)
                pc <= target_q;
            else begin
                if (cap_pcl) pc[DATA_W-1:0]    <= rdata;
                if (cap_pch) pc[PC_W-1:DATA_W] <= rdata;
            end
        end
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SP_W     = 8,
    parameter int IDIS_BIT = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [1:0]               req_op,
    input  logic [2*DATA_W-1:0]      req_addr,
    input  logic                     page_sel,
    output logic [DATA_W+SP_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     mem_we,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [2*DATA_W-1:0]      pc_o,
    output logic [SP_W-1:0]          sp_o,
    output logic [DATA_W-1:0]        status_o,
    output logic                     busy,
    output logic                     done
);
    seq_ctrl_t ctrl;

    stack_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .idis      (status_o[IDIS_BIT]),
        .ctrl      (ctrl),
        .busy      (busy),
        .done      (done)
    );

    stack_seq_regs #(
        .DATA_W   (DATA_W),
        .SP_W     (SP_W),
        .IDIS_BIT (IDIS_BIT)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .accept      (ctrl.accept),
        .wsrc        (ctrl.wsrc),
        .sp_dec      (ctrl.sp_dec),
        .sp_inc      (ctrl.sp_inc),
        .cap_ps      (ctrl.cap_ps),
        .cap_pcl     (ctrl.cap_pcl),
        .cap_pch     (ctrl.cap_pch),
        .load_target (ctrl.load_target),
        .set_idis    (ctrl.set_idis),
        .req_addr    (req_addr),
        .rdata       (mem_rdata),
        .pc          (pc_o),
        .sp          (sp_o),
        .status      (status_o),
        .wdata       (mem_wdata)
    );

    stack_seq_agen #(
        .PAGE_W (DATA_W),
        .SP_W   (SP_W)
    ) u_agen (
        .page_sel (page_sel),
        .sp       (sp_o),
        .pre_inc  (ctrl.rd_pre_inc),
        .addr     (mem_addr)
    );

    assign mem_we = ctrl.mem_we;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int DATA_W   = 8,
    parameter int SP_W     = 8,
    parameter int IDIS_BIT = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic [1:0]             req_op,
    input logic                   page_sel,
    input logic [DATA_W+SP_W-1:0] mem_addr,
    input logic                   mem_we,
    input logic [SP_W-1:0]        sp_o,
    input logic [DATA_W-1:0]      status_o,
    input logic                   busy,
    input logic                   done
);
    AST_PAGE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_addr[DATA_W+SP_W-1:SP_W+1] == '0 && mem_addr[SP_W] == page_sel)); // R2

    AST_WRITE_LOWERS_SP: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_o == $past(sp_o) - SP_W'(1))); // R3

    AST_MASKED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_op == 2'b10 && status_o[IDIS_BIT]) |=> !busy); // R7

    AST_DONE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_NO_IDLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_we); // R10

    AST_SP_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(sp_o)); // R11
endmodule

bind stack_seq stack_seq_chk #(
    .DATA_W   (DATA_W),
    .SP_W     (SP_W),
    .IDIS_BIT (IDIS_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .page_sel  (page_sel),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .sp_o      (sp_o),
    .status_o  (status_o),
    .busy      (busy),
    .done      (done)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [15:0] req_addr = '0;
    logic        page_sel = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;
    logic [7:0]  status_o;
    logic        busy;
    logic        done;

    logic        pre_we = 1'b0;
    logic [8:0]  pre_addr = '0;
    logic [7:0]  pre_data = '0;
    logic [7:0]  mem [0:511];

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_seq dut_i (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .page_sel (page_sel), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_we (mem_we), .mem_rdata (mem_rdata),
        .pc_o (pc_o), .sp_o (sp_o), .status_o (status_o), .busy (busy), .done (done)
    );

    always @(posedge clk) begin
        if (pre_we)
            mem[pre_addr] <= pre_data;
        else if (mem_we)
            mem[mem_addr[8:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[8:0]];
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag, input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
        check(pc_o == pc, {tag, " pc"}, pc_o, pc);
        check(sp_o == sp, {tag, " sp"}, sp_o, sp);
        check(status_o == st, {tag, " status"}, status_o, st);
    endtask

    task automatic check_mem(input string tag, input logic [8:0] a, input logic [7:0] v);
        check(mem[a] == v, {tag, " mem"}, mem[a], v);
    endtask

    task automatic preload(input logic [8:0] a, input logic [7:0] v);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = v;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    // Issues one request, counts busy cycles, leaves the bench at the done cycle
    task automatic run_req(input logic [1:0] op, input logic [15:0] a, input int exp_busy, input string tag);
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 40) begin
            if (busy) n++;
            @(negedge clk);
        end
        check(done == 1'b1, {tag, " R9 done seen"}, done, 1);
        check(n == exp_busy, {tag, " busy cycles"}, n, exp_busy);
    endtask

    task automatic done_drops(input string tag);
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
    endtask

    task automatic t_reset;
        check_regs("R1 reset", 16'h0000, 8'hFF, 8'h00);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
    endtask

    task automatic t_nested_calls;
        page_sel = 1'b0;
        run_req(2'b00, 16'h1234, 2, "R3 call1");
        check_regs("R3 call1", 16'h1234, 8'hFD, 8'h00);
        check_mem("R3 call1 hi", 9'h0FF, 8'h00);
        done_drops("R3 call1");
        run_req(2'b00, 16'hABCD, 2, "R3 call2");
        check_regs("R3 call2", 16'hABCD, 8'hFB, 8'h00);
        check_mem("R3 call2 hi", 9'h0FD, 8'h12);
        check_mem("R3 call2 lo", 9'h0FC, 8'h34);
        done_drops("R3 call2");
        run_req(2'b01, 16'h0000, 3, "R4 ret1");
        check_regs("R4 ret1", 16'h1234, 8'hFD, 8'h00);
        run_req(2'b01, 16'h0000, 3, "R4 ret2");
        check_regs("R11 R4 ret2 restores", 16'h0000, 8'hFF, 8'h00);
    endtask

    task automatic t_interrupt_page1;
        page_sel = 1'b1;
        run_req(2'b00, 16'h5A3C, 2, "R2 call page1");
        check_regs("R2 call page1", 16'h5A3C, 8'hFD, 8'h00);
        run_req(2'b10, 16'hF00D, 3, "R5 entry");
        check_regs("R5 entry", 16'hF00D, 8'hFA, 8'h04);
        check_mem("R5 pch", 9'h1FD, 8'h5A);
        check_mem("R5 pcl", 9'h1FC, 8'h3C);
        check_mem("R5 status", 9'h1FB, 8'h00);
        check_mem("R2 page0 untouched", 9'h0FD, 8'h12);
    endtask

    task automatic t_masked;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b10; req_addr = 16'h1111;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(busy == 1'b0 && done == 1'b0, "R7 masked no activity", {busy, done}, 0);
            @(negedge clk);
        end
        check_regs("R7 masked", 16'hF00D, 8'hFA, 8'h04);
        check_mem("R7 masked no write", 9'h1FA, 8'h00);
    endtask

    task automatic t_ignore_busy;
        int n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_addr = 16'h2222;
        @(negedge clk);
        req_op = 2'b01; req_addr = 16'h9999;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && n < 40) begin n++; @(negedge clk); end
        check_regs("R10 call done", 16'h2222, 8'hF8, 8'h04);
        @(negedge clk);
        check(busy == 1'b0, "R10 ignored request not started", busy, 0);
        check_regs("R10 after", 16'h2222, 8'hF8, 8'h04);
        check_mem("R10 hi", 9'h1FA, 8'hF0);
        check_mem("R10 lo", 9'h1F9, 8'h0D);
        run_req(2'b01, 16'h0000, 3, "R4 ret page1");
        check_regs("R4 ret page1", 16'hF00D, 8'hFA, 8'h04);
    endtask

    task automatic t_reti;
        run_req(2'b11, 16'h0000, 4, "R6 reti");
        check_regs("R6 R11 reti", 16'h5A3C, 8'hFD, 8'h00);
        run_req(2'b01, 16'h0000, 3, "R11 final ret");
        check_regs("R11 final ret", 16'h0000, 8'hFF, 8'h00);
    endtask

    task automatic t_wrap;
        page_sel = 1'b0;
        preload(9'h000, 8'h77);
        preload(9'h001, 8'h99);
        run_req(2'b01, 16'h0000, 3, "R8 pop wrap");
        check_regs("R8 pop wrap", 16'h9977, 8'h01, 8'h00);
        preload(9'h000, 8'h00);
        preload(9'h001, 8'h00);
        run_req(2'b00, 16'h4444, 2, "R8 push wrap");
        check_regs("R8 push wrap", 16'h4444, 8'hFF, 8'h00);
        check_mem("R8 push wrap hi", 9'h001, 8'h99);
        check_mem("R8 push wrap lo", 9'h000, 8'h77);
    endtask

    task automatic t_status_roundtrip;
        preload(9'h000, 8'hC3);
        preload(9'h001, 8'hBB);
        preload(9'h002, 8'hAA);
        run_req(2'b11, 16'h0000, 4, "R6 reti status");
        check_regs("R6 reti status", 16'hAABB, 8'h02, 8'hC3);
        run_req(2'b10, 16'h1357, 3, "R5 entry status");
        check_regs("R5 entry status", 16'h1357, 8'hFF, 8'hC7);
        check_mem("R5 stacked status", 9'h000, 8'hC3);
        check_mem("R5 stacked pcl", 9'h001, 8'hBB);
        check_mem("R5 stacked pch", 9'h002, 8'hAA);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_nested_calls();
        t_interrupt_page1();
        t_masked();
        t_ignore_busy();
        t_reti();
        t_wrap();
        t_status_roundtrip();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule